// File: doc/BRIEF.md
# Two-Wire Bus Transaction Monitor

This block watches the clock and data lines of a two-wire serial bus without ever driving them. It turns what it sees into a stream of classified events. Both lines are first brought into the system clock domain and cleaned by a short majority filter. A small state machine then recognises bus conditions and assembles frames.

Each transaction begins with a start condition. The first 9-clock frame after it is taken as the address byte, which carries the transfer direction. Every later frame is a data byte that inherits that direction. Frames continue until a stop condition or a repeated start. Every frame yields one byte event, and the event also carries the acknowledge bit.

Events leave through a valid/ready port. The bus cannot be paused, so an event that finds the output slot still occupied is dropped and a sticky overflow flag is raised.

Top module: `twowire_monitor`

## Requirements
- R1: After reset, `evt_valid` and `evt_overflow` are 0.
- R2: When no transaction is open, a falling data line while the clock line is high produces a start event with code 0 on `evt_type`. A transaction is then open.
- R3: A start condition seen while a transaction is open produces a repeated-start event with code 1. The next frame after it is treated as an address frame.
- R4: A rising data line while the clock line is high produces a stop event with code 2 and closes the transaction. The next start is then reported with code 0. Clock edges while no transaction is open produce no event.
- R5: A frame is 9 rising clock edges. The first 8 data-line samples form `evt_byte`, most significant bit first. `evt_ack` is 1 when the ninth sample is 0 (acknowledge) and 0 when it is 1 (not acknowledged).
- R6: In the first frame after a start or repeated start, bit 0 of the byte is the direction: 0 means write and 1 means read. The event type is code 3 for write and code 4 for read. The reported byte has bit 0 cleared.
- R7: Each later frame produces a data event, any number of them back to back. The code is 5 when the last address frame gave write and 6 when it gave read.
- R8: Data-line changes while the clock line is low are not captured and produce no event.
- R9: A pulse on either line that lasts a single system clock cycle is filtered out and produces no event.
- R10: While `evt_valid` is 1 and `evt_ready` is 0, the outputs hold steady. An event that arrives in that condition is dropped and sets `evt_overflow`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| evt_ready | input | 1 | Consumer accepts the current event |
| evt_valid | output | 1 | An event is presented |
| evt_type | output | 3 | Event code: 0 start, 1 repeated start, 2 stop, 3/4 address write/read, 5/6 data write/read |
| evt_byte | output | DATA_W | Byte value for address and data events |
| evt_ack | output | 1 | 1 when the frame was acknowledged |
| evt_overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
On every cycle, the assertions check several properties:
- a filtered line changes only after its newest sample agrees with the new value;
- the assembled shift register stays frozen while the clock line is low;
- a stop always returns the machine to idle with the direction cleared;
- address events always show bit 0 cleared and move the machine into data collection;
- a stalled output holds steady, and the overflow flag is sticky.

Only the bench's scenarios can show the event sequences themselves: the start versus repeated-start labels, the codes that inherit the direction, the acknowledge values, and the suppression of glitches and idle clocking.

// File: rtl/twowire_monitor_pkg.sv
package twowire_monitor_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADDR_WR = 3'd3,
    EV_ADDR_RD = 3'd4,
    EV_DATA_WR = 3'd5,
    EV_DATA_RD = 3'd6
  } twm_ev_e;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_ADDR   = 2'd1,
    ST_DATA   = 2'd2
  } twm_state_e;

endpackage

// File: rtl/twm_rst_sync.sv
module twm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/twm_line_cond.sv
module twm_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_f
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;
  logic                   filt_q;
  logic                   newest;
  logic                   maj_d;

  assign newest = sync_q[SYNC_STAGES-1];

  always_comb begin
    maj_d = (newest & hist_q[0]) | (newest & hist_q[1]) | (hist_q[0] & hist_q[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[0], newest};
      filt_q <= maj_d;
    end
  end

  assign line_f = filt_q;

  AST_FILTER_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (hist_q[0] == filt_q)); // R9
endmodule

// File: rtl/twm_frame_decoder.sv
module twm_frame_decoder
  import twowire_monitor_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  output logic              ev_stb,
  output twm_ev_e           ev_type,
  output logic [DATA_W-1:0] ev_byte,
  output logic              ev_ack
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  twm_state_e        state_q, state_d;
  logic              scl_p_q, sda_p_q;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dir_q, dir_d;
  logic              start_c, stop_c, bit_c, frame_end;

  always_comb begin
    start_c   = scl_f & scl_p_q & sda_p_q & ~sda_f;
    stop_c    = scl_f & scl_p_q & ~sda_p_q & sda_f;
    bit_c     = scl_f & ~scl_p_q;
    frame_end = bit_c & (cnt_q == LAST_BIT);
  end

  always_comb begin
    state_d = state_q;
    shf_d   = shf_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    ev_stb  = 1'b0;
    ev_type = EV_START;
    ev_byte = '0;
    ev_ack  = 1'b0;
    case (state_q)
      ST_SEARCH: begin
        if (start_c) begin
          ev_stb  = 1'b1;
          ev_type = EV_START;
          state_d = ST_ADDR;
          cnt_d   = '0;
          shf_d   = '0;
        end
      end
      default: begin
        if (start_c) begin
          ev_stb  = 1'b1;
          ev_type = EV_RSTART;
          state_d = ST_ADDR;
          cnt_d   = '0;
          shf_d   = '0;
        end else if (stop_c) begin
          ev_stb  = 1'b1;
          ev_type = EV_STOP;
          state_d = ST_SEARCH;
          dir_d   = 1'b0;
          cnt_d   = '0;
          shf_d   = '0;
        end else if (frame_end) begin
          ev_stb = 1'b1;
          ev_ack = ~sda_f;
          cnt_d  = '0;
          shf_d  = '0;
          if (state_q == ST_ADDR) begin
            dir_d   = shf_q[0];
            ev_type = shf_q[0] ? EV_ADDR_RD : EV_ADDR_WR;
            ev_byte = {shf_q[DATA_W-1:1], 1'b0};
            state_d = ST_DATA;
          end else begin
            ev_type = dir_q ? EV_DATA_RD : EV_DATA_WR;
            ev_byte = shf_q;
          end
        end else if (bit_c) begin
          shf_d = {shf_q[DATA_W-2:0], sda_f};
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      shf_q   <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      scl_p_q <= scl_f;
      sda_p_q <= sda_f;
      shf_q   <= shf_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
    end
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stb && ev_type == EV_STOP) |=> (state_q == ST_SEARCH && !dir_q)); // R4
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stb && (ev_type == EV_START || ev_type == EV_RSTART)) |=> (state_q == ST_ADDR && cnt_q == '0)); // R3
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stb && (ev_type == EV_ADDR_WR || ev_type == EV_ADDR_RD)) |-> !ev_byte[0]); // R6
  AST_ADDR_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stb && (ev_type == EV_ADDR_WR || ev_type == EV_ADDR_RD)) |=> state_q == ST_DATA); // R6
  AST_LOW_CLK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_f |=> $stable(shf_q)); // R8
endmodule

// File: rtl/twm_event_out.sv
module twm_event_out
  import twowire_monitor_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_stb,
  input  twm_ev_e           ev_type,
  input  logic [DATA_W-1:0] ev_byte,
  input  logic              ev_ack,
  input  logic              ready_i,
  output logic              valid_o,
  output twm_ev_e           type_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              ack_o,
  output logic              overflow_o
);
  logic              valid_q, valid_d;
  twm_ev_e           type_q, type_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              ack_q, ack_d;
  logic              ovf_q, ovf_d;
  logic              slot_free, load_en, drop_en;

  always_comb begin
    slot_free = !valid_q || ready_i;
    load_en   = ev_stb && slot_free;
    drop_en   = ev_stb && !slot_free;
    valid_d   = load_en ? 1'b1 : (ready_i ? 1'b0 : valid_q);
    type_d    = load_en ? ev_type : type_q;
    byte_d    = load_en ? ev_byte : byte_q;
    ack_d     = load_en ? ev_ack  : ack_q;
    ovf_d     = ovf_q | drop_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      type_q  <= EV_START;
      byte_q  <= '0;
      ack_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      type_q  <= type_d;
      byte_q  <= byte_d;
      ack_q   <= ack_d;
      ovf_q   <= ovf_d;
    end
  end

  assign valid_o    = valid_q;
  assign type_o     = type_q;
  assign byte_o     = byte_q;
  assign ack_o      = ack_q;
  assign overflow_o = ovf_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(type_q) && $stable(byte_q) && $stable(ack_q))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R10
endmodule

// File: rtl/twowire_monitor.sv
module twowire_monitor
  import twowire_monitor_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              evt_ready,
  output logic              evt_valid,
  output logic [2:0]        evt_type,
  output logic [DATA_W-1:0] evt_byte,
  output logic              evt_ack,
  output logic              evt_overflow
);
  localparam int N_LINES = 2;

  logic               rst_n_s;
  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic               ev_stb;
  twm_ev_e            ev_type, out_type;
  logic [DATA_W-1:0]  ev_byte;
  logic               ev_ack;

  assign raw_lines = {sda_i, scl_i};

  twm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    twm_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .line_i (raw_lines[g]),
      .line_f (filt_lines[g])
    );
  end

  twm_frame_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .scl_f   (filt_lines[0]),
    .sda_f   (filt_lines[1]),
    .ev_stb  (ev_stb),
    .ev_type (ev_type),
    .ev_byte (ev_byte),
    .ev_ack  (ev_ack)
  );

  twm_event_out #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ev_stb     (ev_stb),
    .ev_type    (ev_type),
    .ev_byte    (ev_byte),
    .ev_ack     (ev_ack),
    .ready_i    (evt_ready),
    .valid_o    (evt_valid),
    .type_o     (out_type),
    .byte_o     (evt_byte),
    .ack_o      (evt_ack),
    .overflow_o (evt_overflow)
  );

  assign evt_type = out_type;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(!rst_n_s) |-> (!evt_valid && !evt_overflow)); // R1
endmodule

// File: tb/twowire_monitor_tb.sv
module twowire_monitor_tb;
  localparam int HALF = 10;

  logic       clk;
  logic       rst_n;
  logic       scl, sda, ready;
  logic       evt_valid, evt_ack, evt_overflow;
  logic [2:0] evt_type;
  logic [7:0] evt_byte;

  int checks = 0;
  int errors = 0;

  logic [2:0] log_t [64];
  logic [7:0] log_b [64];
  logic       log_a [64];
  int         log_n = 0;

  twowire_monitor u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl),
    .sda_i        (sda),
    .evt_ready    (ready),
    .evt_valid    (evt_valid),
    .evt_type     (evt_type),
    .evt_byte     (evt_byte),
    .evt_ack      (evt_ack),
    .evt_overflow (evt_overflow)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && evt_valid && ready && log_n < 64) begin
      log_t[log_n] = evt_type;
      log_b[log_n] = evt_byte;
      log_a[log_n] = evt_ack;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int idx, input int t, input int b, input int a,
                           input string req);
    check(log_t[idx] == 3'(t), req, $sformatf("event %0d type", idx), int'(log_t[idx]), t);
    if (t >= 3) begin
      check(log_b[idx] == 8'(b), req, $sformatf("event %0d byte", idx), int'(log_b[idx]), b);
      check(log_a[idx] == a[0], req, $sformatf("event %0d ack", idx), int'(log_a[idx]), a);
    end
  endtask

  task automatic hold();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b0; hold(); scl = 1'b0; hold();
  endtask

  task automatic bus_rstart();
    sda = 1'b1; hold(); scl = 1'b1; hold(); sda = 1'b0; hold(); scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda = 1'b0; hold(); scl = 1'b1; hold(); sda = 1'b1; hold();
  endtask

  task automatic bus_bit(input bit b, input bit noisy);
    if (noisy) begin
      sda = ~b; hold(); sda = b; hold(); sda = ~b; hold();
    end
    sda = b; hold(); scl = 1'b1; hold(); scl = 1'b0; hold();
  endtask

  task automatic bus_byte(input logic [7:0] v, input bit nack, input bit noisy);
    for (int i = 7; i >= 0; i--) bus_bit(v[i], noisy);
    bus_bit(nack, noisy);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    check(evt_valid == 1'b0, "R1", "valid after reset", int'(evt_valid), 0);
    check(evt_overflow == 1'b0, "R1", "overflow after reset", int'(evt_overflow), 0);
  endtask

  task automatic t_write();
    int base = log_n;
    bus_start();
    bus_byte(8'hA0, 1'b0, 1'b0);
    bus_byte(8'h3C, 1'b0, 1'b0);
    bus_byte(8'hFF, 1'b1, 1'b0);
    bus_stop(); settle();
    check(log_n - base == 5, "R7", "write event count", log_n - base, 5);
    expect_ev(base + 0, 0, 0, 0, "R2");
    expect_ev(base + 1, 3, 8'hA0, 1, "R6");
    expect_ev(base + 2, 5, 8'h3C, 1, "R5");
    expect_ev(base + 3, 5, 8'hFF, 0, "R7");
    expect_ev(base + 4, 2, 0, 0, "R4");
  endtask

  task automatic t_read_rstart();
    int base = log_n;
    bus_start();
    bus_byte(8'hA0, 1'b0, 1'b0);
    bus_byte(8'h01, 1'b0, 1'b0);
    bus_rstart();
    bus_byte(8'hA1, 1'b0, 1'b0);
    bus_byte(8'h5A, 1'b1, 1'b0);
    bus_stop(); settle();
    check(log_n - base == 7, "R3", "read event count", log_n - base, 7);
    expect_ev(base + 0, 0, 0, 0, "R2");
    expect_ev(base + 1, 3, 8'hA0, 1, "R6");
    expect_ev(base + 2, 5, 8'h01, 1, "R7");
    expect_ev(base + 3, 1, 0, 0, "R3");
    expect_ev(base + 4, 4, 8'hA0, 1, "R6");
    expect_ev(base + 5, 6, 8'h5A, 0, "R7");
    expect_ev(base + 6, 2, 0, 0, "R4");
  endtask

  task automatic t_idle_then_start();
    int base = log_n;
    for (int i = 0; i < 4; i++) begin
      scl = 1'b0; hold(); scl = 1'b1; hold();
    end
    settle();
    check(log_n == base, "R4", "idle clocking events", log_n - base, 0);
    bus_start(); bus_stop(); settle();
    check(log_n - base == 2, "R4", "start/stop count", log_n - base, 2);
    expect_ev(base + 0, 0, 0, 0, "R4");
    expect_ev(base + 1, 2, 0, 0, "R4");
  endtask

  task automatic t_low_noise();
    int base = log_n;
    bus_start();
    bus_byte(8'h96, 1'b0, 1'b1);
    bus_stop(); settle();
    check(log_n - base == 3, "R8", "noisy frame count", log_n - base, 3);
    expect_ev(base + 1, 3, 8'h96, 1, "R8");
  endtask

  task automatic t_glitch();
    int base = log_n;
    @(negedge clk); scl = 1'b0; @(negedge clk); scl = 1'b1;
    settle();
    @(negedge clk); sda = 1'b0; @(negedge clk); sda = 1'b1;
    settle();
    check(log_n == base, "R9", "glitch events", log_n - base, 0);
    bus_start(); bus_stop(); settle();
    check(log_n - base == 2 && log_t[base] == 3'd0, "R9", "start after glitches",
          int'(log_t[base]), 0);
  endtask

  task automatic t_overflow();
    int base = log_n;
    logic [2:0] held;
    ready = 1'b0;
    bus_start();
    bus_byte(8'hA0, 1'b0, 1'b0);
    settle();
    held = evt_type;
    check(evt_valid == 1'b1, "R10", "valid while stalled", int'(evt_valid), 1);
    check(evt_type == 3'd0, "R10", "held type", int'(evt_type), 0);
    check(evt_overflow == 1'b1, "R10", "overflow set", int'(evt_overflow), 1);
    repeat (5) @(negedge clk);
    check(evt_type == held && evt_valid, "R10", "output stable", int'(evt_type), int'(held));
    ready = 1'b1;
    bus_stop(); settle();
    check(log_n - base == 2, "R10", "events after stall", log_n - base, 2);
    expect_ev(base + 0, 0, 0, 0, "R10");
    expect_ev(base + 1, 2, 0, 0, "R10");
    check(evt_overflow == 1'b1, "R10", "overflow sticky", int'(evt_overflow), 1);
  endtask

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_read_rstart();
    t_idle_then_start();
    t_low_noise();
    t_glitch();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule